// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Store with Hit Comparator

This block holds the tag and status information of a direct-mapped cache, one entry per index. Each entry stores a 12-bit tag and three status bits. A lookup presents an index and an incoming tag. Without waiting for a clock, the block returns the stored tag, the stored status bits and a hit flag that compares the stored tag with the incoming one.

Tag and status fields are written on the rising clock edge, and each field has its own write enable. An active-low clear input invalidates the whole array in one edge by zeroing every status bit. Two chip selects, one active low and one active high, must both be asserted, so several stores can be stacked to give a deeper cache. A mode input sets how the status bits are read. In cache mode they carry valid, dirty and write-through, and the valid bit qualifies the hit. In generic mode they are three user bits that have no effect inside the block.

Each output group has its own enable. An enable does not drive a tri-state pin: it produces a qualifier output, and the data of a group reads zero while that group is not enabled.

Top module: `tag_store_cmp`

## Requirements
- R1: `hit` is high only when both selects are active (`cs_a_n` low, `cs_b` high) and the stored tag at `idx` equals `tag_in`. When either select is inactive, `hit` is low.
- R2: Reads and lookups are combinational. `tag_out`, `stat_out` and `hit` follow a change of `idx` or `tag_in` with no clock edge in between.
- R3: The status layout is bit 0 valid, bit 1 dirty, bit 2 write-through. With `gen_mode` low, an entry whose valid bit is 0 never hits.
- R4: On a rising edge with `tag_we` high and the block selected, the entry at `idx` takes `tag_in`. The status of that entry is unchanged.
- R5: On a rising edge with `stat_we` high, the block selected and `rst_n` high, the entry at `idx` takes `stat_in`. The tag of that entry is unchanged.
- R6: When `rst_n` is low at a rising edge, the status bits of every entry read 0 after that single edge. Tags are kept.
- R7: While the block is deselected, no tag or status write takes effect.
- R8: `tag_vld` is high exactly when `tag_oe` is high and the block is selected, and `tag_out` reads 0 whenever `tag_vld` is low. `stat_vld` and `stat_out` behave the same way with `stat_oe`. Each enable affects only its own group.
- R9: With `gen_mode` high, `hit` is the raw tag comparison under the selects, and the status bits have no influence on it.
- R10: When a tag write and a clear fall on the same edge, the tag write completes and the status bits end cleared, even if a status write was requested on that edge.
- R11: The clear acts even while the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and clear |
| rst_n | input | 1 | Active-low synchronous clear of all status bits |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| gen_mode | input | 1 | 0: status bits have cache meaning; 1: generic user bits |
| idx | input | IDX_W | Entry index |
| tag_in | input | TAG_W | Incoming tag for compare and write |
| tag_we | input | 1 | Tag field write enable |
| stat_in | input | 3 | Status bits to write |
| stat_we | input | 1 | Status field write enable |
| tag_oe | input | 1 | Tag output enable |
| stat_oe | input | 1 | Status output enable |
| tag_out | output | TAG_W | Stored tag at idx (0 when not enabled) |
| tag_vld | output | 1 | Qualifier for tag_out |
| stat_out | output | 3 | Stored status at idx (0 when not enabled) |
| stat_vld | output | 1 | Qualifier for stat_out |
| hit | output | 1 | Tag match, qualified by the selects and, in cache mode, by valid |

## Verification
The bench builds the store with `IDX_W` = 4, so it has 16 entries, and keeps the default 12-bit tag. With that depth the bench can visit every entry after each clear and each bulk write, so it shows that a single clear edge reaches all rows, including ones that were not addressed. The small depth also lets the bench cover every one of the eight status codes across the entries in both status modes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ST_W     = 3;
  localparam int ST_VALID = 0;
  localparam int ST_DIRTY = 1;
  localparam int ST_WTHRU = 2;

  typedef logic [ST_W-1:0] status_t;

  // Hit rule: selected, tags equal, and valid unless status is generic.
  function automatic logic hit_rule(input logic sel, input logic tag_eq,
                                    input logic gen, input logic vbit);
    return sel & tag_eq & (gen | vbit);
  endfunction

  // Output gating for one enabled group.
  function automatic logic group_on(input logic sel, input logic oe);
    return sel & oe;
  endfunction
endpackage

// File: rtl/tsc_tag_array.sv
module tsc_tag_array #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/tsc_status_array.sv
module tsc_status_array
  import tsc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  status_t          wdata,
  output status_t          rdata
);
  localparam int DEPTH = 1 << IDX_W;

  status_t rows [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    always_ff @(posedge clk) begin
      if (clr)                             rows[e] <= '0;
      else if (we && idx == IDX_W'(e))     rows[e] <= wdata;
    end
  end

  assign rdata = rows[idx];
endmodule

// File: rtl/tsc_compare.sv
module tsc_compare
  import tsc_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic [TAG_W-1:0] stored_tag,
  input  logic [TAG_W-1:0] probe_tag,
  input  logic             sel,
  input  logic             gen_mode,
  input  logic             vbit,
  output logic             hit
);
  logic tag_eq;
  assign tag_eq = (stored_tag == probe_tag);
  assign hit    = hit_rule(sel, tag_eq, gen_mode, vbit);
endmodule

// File: rtl/tag_store_cmp.sv
module tag_store_cmp
  import tsc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             gen_mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             tag_we,
  input  logic [2:0]       stat_in,
  input  logic             stat_we,
  input  logic             tag_oe,
  input  logic             stat_oe,
  output logic [TAG_W-1:0] tag_out,
  output logic             tag_vld,
  output logic [2:0]       stat_out,
  output logic             stat_vld,
  output logic             hit
);
  // Named internal events, visible to the bound checker.
  logic             sel;
  logic             tag_wr;
  logic             st_wr;
  logic             st_clr;
  logic [TAG_W-1:0] tag_rd;
  status_t          st_rd;

  assign sel    = ~cs_a_n & cs_b;
  assign tag_wr = sel & tag_we;
  assign st_clr = ~rst_n;
  assign st_wr  = sel & stat_we & rst_n;

  tsc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk   (clk),
    .we    (tag_wr),
    .idx   (idx),
    .wdata (tag_in),
    .rdata (tag_rd)
  );

  tsc_status_array #(.IDX_W(IDX_W)) u_stat (
    .clk   (clk),
    .clr   (st_clr),
    .we    (st_wr),
    .idx   (idx),
    .wdata (stat_in),
    .rdata (st_rd)
  );

  tsc_compare #(.TAG_W(TAG_W)) u_cmp (
    .stored_tag (tag_rd),
    .probe_tag  (tag_in),
    .sel        (sel),
    .gen_mode   (gen_mode),
    .vbit       (st_rd[ST_VALID]),
    .hit        (hit)
  );

  assign tag_vld  = group_on(sel, tag_oe);
  assign stat_vld = group_on(sel, stat_oe);
  assign tag_out  = tag_vld  ? tag_rd : '0;
  assign stat_out = stat_vld ? st_rd  : '0;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             gen_mode,
  input logic [IDX_W-1:0] idx,
  input logic [TAG_W-1:0] tag_in,
  input logic [2:0]       stat_in,
  input logic [TAG_W-1:0] tag_out,
  input logic             tag_vld,
  input logic [2:0]       stat_out,
  input logic             stat_vld,
  input logic             hit,
  input logic             tag_wr,
  input logic             st_wr,
  input logic             st_clr
);
  // R1: deselected store never reports a hit
  a_r1_no_hit_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !hit);

  // R3: cache mode, visible invalid entry never hits
  a_r3_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_mode && stat_vld && !stat_out[0]) |-> !hit);

  // R4: tag write visible next cycle at the same index
  a_r4_tag_written: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr |=> (!$stable(idx) || !tag_vld || tag_out == $past(tag_in)));

  // R5: status write visible next cycle at the same index
  a_r5_status_written: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> (!$stable(idx) || !stat_vld || stat_out == $past(stat_in)));

  // R6: any row read right after a clear edge shows zero status
  a_r6_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_clr) |-> (stat_out == 3'b000));

  // R8: disabled groups read zero
  a_r8_tag_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_vld |-> (tag_out == '0));
  a_r8_stat_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_vld |-> (stat_out == 3'b000));

  // R9: generic mode, an equal visible tag always hits
  a_r9_generic_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_mode && tag_vld && tag_out == tag_in) |-> hit);
endmodule

bind tag_store_cmp tsc_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .gen_mode (gen_mode),
  .idx      (idx),
  .tag_in   (tag_in),
  .stat_in  (stat_in),
  .tag_out  (tag_out),
  .tag_vld  (tag_vld),
  .stat_out (stat_out),
  .stat_vld (stat_vld),
  .hit      (hit),
  .tag_wr   (tag_wr),
  .st_wr    (st_wr),
  .st_clr   (st_clr)
);

// File: tb/tag_store_cmp_test.sv
module tag_store_cmp_test;
  localparam int IW = 4;
  localparam int TW = 12;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_a_n = 1'b0, cs_b = 1'b1, gen_mode = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [TW-1:0] tag_in = '0;
  logic          tag_we = 1'b0, stat_we = 1'b0, tag_oe = 1'b1, stat_oe = 1'b1;
  logic [2:0]    stat_in = '0;
  logic [TW-1:0] tag_out;
  logic          tag_vld, stat_vld, hit;
  logic [2:0]    stat_out;

  int checks = 0, errors = 0;
  logic [TW-1:0] exp_tag [N];
  logic [2:0]    exp_st  [N];

  tag_store_cmp #(.IDX_W(IW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .gen_mode(gen_mode),
    .idx(idx), .tag_in(tag_in), .tag_we(tag_we), .stat_in(stat_in),
    .stat_we(stat_we), .tag_oe(tag_oe), .stat_oe(stat_oe), .tag_out(tag_out),
    .tag_vld(tag_vld), .stat_out(stat_out), .stat_vld(stat_vld), .hit(hit)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] pat(input int i, input int salt);
    return TW'((i * 331 + salt * 97 + 5) & 12'hFFF);
  endfunction

  // One edge with the given controls, inputs set at the falling edge.
  task automatic edge_op(input int i, input logic [TW-1:0] t, input logic twe,
                         input logic [2:0] s, input logic swe, input logic clr);
    @(negedge clk);
    idx = IW'(i); tag_in = t; tag_we = twe; stat_in = s; stat_we = swe;
    rst_n = ~clr;
    @(posedge clk);
    @(negedge clk);
    tag_we = 1'b0; stat_we = 1'b0; rst_n = 1'b1;
  endtask

  // Combinational probe: no clock edge between driving and sampling.
  task automatic look(input int i, input logic [TW-1:0] t);
    idx = IW'(i); tag_in = t;
    #1;
  endtask

  task automatic t_reset_state;
    for (int i = 0; i < N; i++) begin
      look(i, 12'h000);
      chk("R6 status zero after clear", {29'd0, stat_out}, 32'd0);
      chk("R3 invalid entry no hit", {31'd0, hit}, 32'd0);
    end
  endtask

  task automatic t_tag_writes;
    for (int i = 0; i < N; i++) begin
      exp_tag[i] = pat(i, 1);
      edge_op(i, exp_tag[i], 1'b1, 3'b111, 1'b0, 1'b0);
    end
    for (int i = 0; i < N; i++) begin
      look(i, 12'h000);
      chk("R4 tag stored", {20'd0, tag_out}, {20'd0, exp_tag[i]});
      chk("R4 status untouched by tag write", {29'd0, stat_out}, 32'd0);
    end
    // R2: swap index with no clock, read follows at once
    look(3, 12'h000); look(9, exp_tag[9]);
    chk("R2 combinational read", {20'd0, tag_out}, {20'd0, exp_tag[9]});
  endtask

  task automatic t_status_and_hit;
    for (int i = 0; i < N; i++) begin
      exp_st[i] = 3'(i % 8);
      edge_op(i, 12'hABC, 1'b0, exp_st[i], 1'b1, 1'b0);
    end
    gen_mode = 1'b0;
    for (int i = 0; i < N; i++) begin
      look(i, exp_tag[i]);
      chk("R5 status stored", {29'd0, stat_out}, {29'd0, exp_st[i]});
      chk("R5 tag untouched by status write", {20'd0, tag_out}, {20'd0, exp_tag[i]});
      chk("R3 hit qualified by valid", {31'd0, hit}, {31'd0, exp_st[i][0]});
      look(i, exp_tag[i] ^ 12'h400);
      chk("R1 tag mismatch no hit", {31'd0, hit}, 32'd0);
    end
  endtask

  task automatic t_generic;
    gen_mode = 1'b1;
    for (int i = 0; i < N; i++) begin
      look(i, exp_tag[i]);
      chk("R9 generic raw compare hit", {31'd0, hit}, 32'd1);
      look(i, exp_tag[i] ^ 12'h001);
      chk("R9 generic mismatch", {31'd0, hit}, 32'd0);
    end
    gen_mode = 1'b0;
  endtask

  task automatic t_deselect;
    cs_a_n = 1'b1;
    edge_op(3, 12'h111, 1'b1, 3'b110, 1'b1, 1'b0);
    look(3, exp_tag[3]);
    chk("R1 no hit while cs_a_n high", {31'd0, hit}, 32'd0);
    cs_a_n = 1'b0; cs_b = 1'b0;
    edge_op(5, 12'h222, 1'b1, 3'b010, 1'b1, 1'b0);
    look(5, exp_tag[5]);
    chk("R1 no hit while cs_b low", {31'd0, hit}, 32'd0);
    cs_b = 1'b1;
    look(3, 12'h000);
    chk("R7 tag kept (cs_a_n)", {20'd0, tag_out}, {20'd0, exp_tag[3]});
    chk("R7 status kept (cs_a_n)", {29'd0, stat_out}, {29'd0, exp_st[3]});
    look(5, exp_tag[5]);
    chk("R7 tag kept (cs_b)", {20'd0, tag_out}, {20'd0, exp_tag[5]});
    chk("R7 status kept (cs_b)", {29'd0, stat_out}, {29'd0, exp_st[5]});
    chk("R1 selected hit returns", {31'd0, hit}, 32'd1);
  endtask

  task automatic t_enables;
    tag_oe = 1'b0;
    look(7, 12'h000);
    chk("R8 tag gated", {20'd0, tag_out}, 32'd0);
    chk("R8 tag_vld low", {31'd0, tag_vld}, 32'd0);
    chk("R8 status still visible", {29'd0, stat_out}, {29'd0, exp_st[7]});
    chk("R8 stat_vld high", {31'd0, stat_vld}, 32'd1);
    tag_oe = 1'b1; stat_oe = 1'b0;
    look(7, 12'h000);
    chk("R8 status gated", {29'd0, stat_out}, 32'd0);
    chk("R8 tag still visible", {20'd0, tag_out}, {20'd0, exp_tag[7]});
    stat_oe = 1'b1; cs_b = 1'b0;
    look(7, 12'h000);
    chk("R8 vld needs select", {30'd0, tag_vld, stat_vld}, 32'd0);
    cs_b = 1'b1;
  endtask

  task automatic t_collide;
    exp_tag[5] = 12'h5A5;
    edge_op(5, exp_tag[5], 1'b1, 3'b111, 1'b1, 1'b1);
    for (int i = 0; i < N; i++) exp_st[i] = 3'b000;
    look(5, exp_tag[5]);
    chk("R10 tag write completes on clear edge", {20'd0, tag_out}, {20'd0, exp_tag[5]});
    chk("R10 status cleared on clear edge", {29'd0, stat_out}, 32'd0);
    for (int i = 0; i < N; i++) begin
      look(i, 12'h000);
      chk("R6 every row cleared", {29'd0, stat_out}, 32'd0);
      chk("R6 tags kept", {20'd0, tag_out}, {20'd0, exp_tag[i]});
    end
  endtask

  task automatic t_clear_deselected;
    for (int i = 0; i < 4; i++) edge_op(i, 12'h000, 1'b0, 3'b101, 1'b1, 1'b0);
    look(2, 12'h000);
    chk("R5 status reloaded", {29'd0, stat_out}, 32'd5);
    cs_a_n = 1'b1;
    edge_op(0, 12'h000, 1'b0, 3'b000, 1'b0, 1'b1);
    cs_a_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      look(i, exp_tag[i]);
      chk("R11 clear while deselected", {29'd0, stat_out}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tag_writes();
    t_status_and_hit();
    t_generic();
    t_deselect();
    t_enables();
    t_collide();
    t_clear_deselected();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule